// File: doc/BRIEF.md
# Remote Terminal Subaddress Buffer Index Manager

This block performs the per-message bookkeeping for one subaddress data buffer of a serial-bus remote terminal. When a message has been received, the surrounding logic presents one strobe with:

- the subaddress;
- the subaddress control word;
- the current data list pointer;
- the received data word count;
- a set of error flags.

One clock later the block returns the results that are written back to memory. These are the updated data list pointer, the new buffer index and a message status word. The status word holds an error flag, the stored word count and a time tag.

The index is a countdown of free buffer slots and lives in the low seven bits of the control word. While it is nonzero, each clean message moves the pointer forward by the number of words stored and takes one off the index. When the index is zero the buffer does not wrap. Instead the pointer stays where it is and the newest message overwrites the last slot.

A control bit can request a standard-priority interrupt when the count runs out. The time tag comes from an internal free-running counter that advances once every `TICK_CYCLES` clocks, which is one 64 µs unit in the target system.

Top module: `rtSaIndexMgr`

## Requirements
- R1: While `rstN` is low and after its release, `resValid` and `irqReq` are 0 until the first message strobe.
- R2: For a message with index (control word bits 6..0) nonzero and all error flags clear, the results appear in the cycle after the strobe: `dataPtrOut` = pointer + words stored (modulo 2^16) and `indexOut` = index − 1.
- R3: A word count input of 0 means 32 words. The pointer then advances by 32, and the status word count field holds 0.
- R4: With index 0 the pointer is returned unchanged and `indexOut` stays 0, whatever the word count.
- R5: If any bit of `errFlags` is set (bit 0 word count, 1 bit count, 2 Manchester, 3 parity, 4 contiguity, 5 illegal subaddress, 6 illegal broadcast subaddress), status bit 13 is 1, and both the pointer and the index are returned unchanged. Otherwise bit 13 is 0.
- R6: Status word bits 12..8 carry `wordCount` as received, and bits 15..14 are 0.
- R7: Status word bits 7..0 carry a time tag that rises by exactly one every `TICK_CYCLES` clocks and wraps at 256. Two messages N·`TICK_CYCLES` clocks apart differ in tag by N.
- R8: `irqReq` pulses for one cycle, together with `resValid`, exactly when a clean message takes the index from 1 to 0 and control word bit 7 is set. No pulse is raised when bit 7 is clear, when the index was already 0, or when the message has an error.
- R9: `resSubaddr` returns the subaddress of the message whose results are presented.
- R10: In a cycle after no strobe, `resValid` and `irqReq` are 0, and the pointer, index and status outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | One-cycle strobe: a message is complete |
| msgSubaddr | input | 5 | Subaddress of the message |
| ctrlWord | input | 16 | Subaddress control word (index in bits 6..0, interrupt enable in bit 7) |
| dataPtrIn | input | 16 | Current data list pointer |
| wordCount | input | 5 | Data words received (0 means 32) |
| errFlags | input | 7 | Error conditions detected in the message |
| resValid | output | 1 | Results valid, one cycle after the strobe |
| resSubaddr | output | 5 | Subaddress belonging to the results |
| dataPtrOut | output | 16 | Updated data list pointer |
| indexOut | output | 7 | Updated buffer index |
| statusWord | output | 16 | Message status word to store |
| irqReq | output | 1 | Standard interrupt request, buffer exhausted |

## Verification
The assertions assume that `msgValid` is a single-cycle strobe. They also assume that the pointer, control word, count and error inputs are stable in the strobe cycle and that the strobe arrives only after reset has been released. The properties compare the results with the inputs held in the strobe cycle, so they are valid only under those conditions. The stimulus meets them: every input is driven on the falling edge, each strobe is held for exactly one clock, and the inputs are released before the next one. The time-tag checks override `TICK_CYCLES` to a small value and space messages by whole tick periods, so the expected tag difference does not depend on the prescaler phase.

// File: rtl/rtSaIdxPkg.sv
package rtSaIdxPkg;

  typedef struct packed {
    logic load;       // capture a new result set
    logic advance;    // move pointer, count index down
    logic raiseIrq;   // buffer count just ran out
    logic flagError;  // message carried an error
  } saStrobe_t;

endpackage

// File: rtl/rtSaTagTimer.sv
module rtSaTagTimer #(
  parameter int TICK_CYCLES = 8000,
  parameter int TAG_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [TAG_W-1:0] tag
);

  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0] preCnt;
  logic             tickNow;

  assign tickNow = (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      tag    <= '0;
    end else begin
      if (tickNow) begin
        preCnt <= '0;
        tag    <= tag + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R7: the tag only ever steps by one
  p_tag_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (tag != $past(tag)) |-> (tag == $past(tag) + 1'b1));

endmodule

// File: rtl/rtSaIdxCtrl.sv
module rtSaIdxCtrl
  import rtSaIdxPkg::*;
#(
  parameter int IDX_W = 7,
  parameter int ERR_N = 7
) (
  input  logic             msgValid,
  input  logic [IDX_W-1:0] index,
  input  logic             irqEnable,
  input  logic [ERR_N-1:0] errFlags,
  output saStrobe_t        strobe
);

  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic errAny;
  logic idxLive;

  assign errAny  = |errFlags;
  assign idxLive = (index != '0);

  always_comb begin
    strobe           = '0;
    strobe.load      = msgValid;
    strobe.flagError = msgValid && errAny;
    strobe.advance   = msgValid && idxLive && !errAny;
    strobe.raiseIrq  = msgValid && !errAny && irqEnable && (index == IDX_ONE);
  end

endmodule

// File: rtl/rtSaIdxDpath.sv
module rtSaIdxDpath
  import rtSaIdxPkg::*;
#(
  parameter int PTR_W = 16,
  parameter int IDX_W = 7,
  parameter int WC_W  = 5,
  parameter int TAG_W = 8,
  parameter int SA_W  = 5,
  parameter int STAT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  saStrobe_t         strobe,
  input  logic [SA_W-1:0]   saIn,
  input  logic [PTR_W-1:0]  ptrIn,
  input  logic [IDX_W-1:0]  idxIn,
  input  logic [WC_W-1:0]   wcIn,
  input  logic [TAG_W-1:0]  tagIn,
  output logic              resValid,
  output logic [SA_W-1:0]   resSubaddr,
  output logic [PTR_W-1:0]  ptrOut,
  output logic [IDX_W-1:0]  idxOut,
  output logic [STAT_W-1:0] statOut,
  output logic              irqOut
);

  localparam int CNT_W = WC_W + 1;
  localparam int PAD_W = STAT_W - 1 - WC_W - TAG_W;
  localparam logic [CNT_W-1:0] FULL_WORDS = CNT_W'(1 << WC_W);

  logic [CNT_W-1:0]  wordsStored;
  logic [PTR_W-1:0]  ptrNext;
  logic [IDX_W-1:0]  idxNext;
  logic [STAT_W-1:0] statNext;

  always_comb begin
    wordsStored = (wcIn == '0) ? FULL_WORDS : CNT_W'(wcIn);
    ptrNext     = strobe.advance ? (ptrIn + PTR_W'(wordsStored)) : ptrIn;
    idxNext     = strobe.advance ? (idxIn - 1'b1) : idxIn;
    statNext    = {{PAD_W{1'b0}}, strobe.flagError, wcIn, tagIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid   <= 1'b0;
      irqOut     <= 1'b0;
      resSubaddr <= '0;
      ptrOut     <= '0;
      idxOut     <= '0;
      statOut    <= '0;
    end else begin
      resValid <= strobe.load;
      irqOut   <= strobe.raiseIrq;
      if (strobe.load) begin
        resSubaddr <= saIn;
        ptrOut     <= ptrNext;
        idxOut     <= idxNext;
        statOut    <= statNext;
      end
    end
  end

  // R4: an exhausted buffer keeps its pointer and index
  p_frozen_ptr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && idxIn == '0) |=> (ptrOut == $past(ptrIn) && idxOut == '0));

  // R5: an errored message moves nothing and is flagged
  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagError |=> (statOut[WC_W+TAG_W] && ptrOut == $past(ptrIn)
                          && idxOut == $past(idxIn)));

  // R8: an interrupt request comes only with a result showing an empty buffer
  p_irq_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (resValid && idxOut == '0));

  // R10: no strobe, no result
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!resValid && !irqOut && $stable(ptrOut) && $stable(idxOut)));

  // R2: a counted message lowers the index by exactly one
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (idxOut == $past(idxIn) - 1'b1));

endmodule

// File: rtl/rtSaIndexMgr.sv
module rtSaIndexMgr
  import rtSaIdxPkg::*;
#(
  parameter int TICK_CYCLES = 8000,
  parameter int IRQ_EN_BIT  = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        msgValid,
  input  logic [4:0]  msgSubaddr,
  input  logic [15:0] ctrlWord,
  input  logic [15:0] dataPtrIn,
  input  logic [4:0]  wordCount,
  input  logic [6:0]  errFlags,
  output logic        resValid,
  output logic [4:0]  resSubaddr,
  output logic [15:0] dataPtrOut,
  output logic [6:0]  indexOut,
  output logic [15:0] statusWord,
  output logic        irqReq
);

  localparam int PTR_W  = 16;
  localparam int IDX_W  = 7;
  localparam int WC_W   = 5;
  localparam int TAG_W  = 8;
  localparam int SA_W   = 5;
  localparam int ERR_N  = 7;
  localparam int STAT_W = 16;

  saStrobe_t        strobe;
  logic [TAG_W-1:0] tagNow;
  logic [IDX_W-1:0] indexField;
  logic             irqEnable;

  assign indexField = ctrlWord[IDX_W-1:0];
  assign irqEnable  = ctrlWord[IRQ_EN_BIT];

  rtSaTagTimer #(
    .TICK_CYCLES (TICK_CYCLES),
    .TAG_W       (TAG_W)
  ) u_timer (
    .clk  (clk),
    .rstN (rstN),
    .tag  (tagNow)
  );

  rtSaIdxCtrl #(
    .IDX_W (IDX_W),
    .ERR_N (ERR_N)
  ) u_ctrl (
    .msgValid  (msgValid),
    .index     (indexField),
    .irqEnable (irqEnable),
    .errFlags  (errFlags),
    .strobe    (strobe)
  );

  rtSaIdxDpath #(
    .PTR_W  (PTR_W),
    .IDX_W  (IDX_W),
    .WC_W   (WC_W),
    .TAG_W  (TAG_W),
    .SA_W   (SA_W),
    .STAT_W (STAT_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .saIn       (msgSubaddr),
    .ptrIn      (dataPtrIn),
    .idxIn      (indexField),
    .wcIn       (wordCount),
    .tagIn      (tagNow),
    .resValid   (resValid),
    .resSubaddr (resSubaddr),
    .ptrOut     (dataPtrOut),
    .idxOut     (indexOut),
    .statOut    (statusWord),
    .irqOut     (irqReq)
  );

endmodule

// File: tb/rtSaIndexMgr_tb.sv
module rtSaIndexMgr_tb;

  localparam int TICK = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic [4:0]  msgSubaddr = '0;
  logic [15:0] ctrlWord = '0;
  logic [15:0] dataPtrIn = '0;
  logic [4:0]  wordCount = '0;
  logic [6:0]  errFlags = '0;
  logic        resValid;
  logic [4:0]  resSubaddr;
  logic [15:0] dataPtrOut;
  logic [6:0]  indexOut;
  logic [15:0] statusWord;
  logic        irqReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  rtSaIndexMgr #(.TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgSubaddr(msgSubaddr),
    .ctrlWord(ctrlWord), .dataPtrIn(dataPtrIn), .wordCount(wordCount),
    .errFlags(errFlags), .resValid(resValid), .resSubaddr(resSubaddr),
    .dataPtrOut(dataPtrOut), .indexOut(indexOut), .statusWord(statusWord),
    .irqReq(irqReq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one strobe at a falling edge; return at the next falling edge with results settled
  task automatic sendMsg(input logic [4:0] sa, input logic [15:0] cw,
                         input logic [15:0] ptr, input logic [4:0] wc,
                         input logic [6:0] err);
    msgValid = 1'b1; msgSubaddr = sa; ctrlWord = cw;
    dataPtrIn = ptr; wordCount = wc; errFlags = err;
    @(negedge clk);
    msgValid = 1'b0; errFlags = '0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "resValid in reset", {31'b0, resValid}, 32'd0);
    chk("R1", "irqReq in reset", {31'b0, irqReq}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "resValid after reset", {31'b0, resValid}, 32'd0);
    chk("R1", "irqReq after reset", {31'b0, irqReq}, 32'd0);
  endtask

  task automatic tAdvance();
    sendMsg(5'd3, 16'h0005, 16'h0100, 5'd4, 7'd0);
    chk("R2", "resValid", {31'b0, resValid}, 32'd1);
    chk("R2", "pointer", {16'b0, dataPtrOut}, 32'h0104);
    chk("R2", "index", {25'b0, indexOut}, 32'd4);
    chk("R9", "subaddress", {27'b0, resSubaddr}, 32'd3);
    chk("R6", "status count/pad", {16'b0, statusWord & 16'hFF00}, 32'h0400);
    sendMsg(5'd17, 16'h007F, 16'hFFFE, 5'd3, 7'd0);
    chk("R2", "pointer wrap", {16'b0, dataPtrOut}, 32'h0001);
    chk("R2", "index from 127", {25'b0, indexOut}, 32'd126);
    chk("R9", "subaddress 17", {27'b0, resSubaddr}, 32'd17);
  endtask

  task automatic tFullWords();
    sendMsg(5'd1, 16'h0002, 16'h0200, 5'd0, 7'd0);
    chk("R3", "pointer +32", {16'b0, dataPtrOut}, 32'h0220);
    chk("R3", "count field 0", {27'b0, statusWord[12:8]}, 32'd0);
    chk("R3", "index", {25'b0, indexOut}, 32'd1);
  endtask

  task automatic tFrozen();
    sendMsg(5'd2, 16'h0080, 16'h0340, 5'd9, 7'd0);
    chk("R4", "pointer frozen", {16'b0, dataPtrOut}, 32'h0340);
    chk("R4", "index stays 0", {25'b0, indexOut}, 32'd0);
    chk("R8", "no irq when already 0", {31'b0, irqReq}, 32'd0);
    chk("R6", "count field 9", {27'b0, statusWord[12:8]}, 32'd9);
    chk("R5", "no error bit", {31'b0, statusWord[13]}, 32'd0);
  endtask

  task automatic tErrors();
    for (int i = 0; i < 7; i++) begin
      sendMsg(5'd4, 16'h0085, 16'h0500, 5'd6, 7'(1 << i));
      chk("R5", "error bit", {31'b0, statusWord[13]}, 32'd1);
      chk("R5", "pointer held", {16'b0, dataPtrOut}, 32'h0500);
      chk("R5", "index held", {25'b0, indexOut}, 32'd5);
    end
    sendMsg(5'd4, 16'h0081, 16'h0500, 5'd6, 7'h48);
    chk("R8", "no irq on errored 1->0", {31'b0, irqReq}, 32'd0);
    chk("R5", "index held at 1", {25'b0, indexOut}, 32'd1);
    chk("R6", "pad bits zero", {30'b0, statusWord[15:14]}, 32'd0);
  endtask

  task automatic tIrq();
    sendMsg(5'd6, 16'h0081, 16'h0600, 5'd2, 7'd0);
    chk("R8", "irq on 1->0", {31'b0, irqReq}, 32'd1);
    chk("R8", "index 0", {25'b0, indexOut}, 32'd0);
    @(negedge clk);
    chk("R8", "irq one cycle", {31'b0, irqReq}, 32'd0);
    sendMsg(5'd6, 16'h0001, 16'h0600, 5'd2, 7'd0);
    chk("R8", "irq disabled", {31'b0, irqReq}, 32'd0);
    sendMsg(5'd6, 16'h0082, 16'h0600, 5'd2, 7'd0);
    chk("R8", "no irq 2->1", {31'b0, irqReq}, 32'd0);
  endtask

  task automatic tTag();
    logic [7:0] t1;
    sendMsg(5'd7, 16'h0003, 16'h0000, 5'd1, 7'd0);
    t1 = statusWord[7:0];
    repeat (3 * TICK - 1) @(negedge clk);
    sendMsg(5'd7, 16'h0003, 16'h0000, 5'd1, 7'd0);
    chk("R7", "tag step of 3", {24'b0, statusWord[7:0] - t1}, 32'd3);
    t1 = statusWord[7:0];
    repeat (260 * TICK - 1) @(negedge clk);
    sendMsg(5'd7, 16'h0003, 16'h0000, 5'd1, 7'd0);
    chk("R7", "tag wraps", {24'b0, statusWord[7:0] - t1}, 32'd4);
  endtask

  task automatic tIdle();
    logic [15:0] p;
    logic [6:0]  x;
    logic [15:0] s;
    sendMsg(5'd9, 16'h0089, 16'h0700, 5'd5, 7'd0);
    p = dataPtrOut; x = indexOut; s = statusWord;
    dataPtrIn = 16'hAAAA; ctrlWord = 16'h0081; wordCount = 5'd31; errFlags = 7'h7F;
    repeat (2) @(negedge clk);
    chk("R10", "resValid low", {31'b0, resValid}, 32'd0);
    chk("R10", "irqReq low", {31'b0, irqReq}, 32'd0);
    chk("R10", "pointer held", {16'b0, dataPtrOut}, {16'b0, p});
    chk("R10", "index held", {25'b0, indexOut}, {25'b0, x});
    chk("R10", "status held", {16'b0, statusWord}, {16'b0, s});
    errFlags = '0;
  endtask

  initial begin
    @(negedge clk);
    tReset();
    tAdvance();
    tFullWords();
    tFrozen();
    tErrors();
    tIrq();
    tTag();
    tIdle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule